// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block is a small indexed register file that decides which shared output pins carry the interrupt and DMA request lines of a parallel port and two UARTs. A host first raises the configuration-state input. It then writes an index byte through the index port and reads or writes the routing register that the index names through the data port. Three routing registers exist. One picks a DMA channel for the parallel port. One picks an interrupt pin for the parallel port. One holds two 4-bit fields that pick the interrupt pins of the two UARTs.

Every output pin has a value and an output enable, and the enable models a tristate driver. A pin that no source claims has its enable low. Each UART drives its pin only while its OUT2 modem-control bit is set. A dedicated code in the second UART's field makes both UARTs share the first UART's pin, which is then driven when either OUT2 bit is set.

Top module: `irq_dma_router`

## Requirements
- R1: After reset, the index register and all three routing registers hold 00h, and every IRQ and DRQ output enable is low.
- R2: Writes through either port (addr_sel_i 0 = index, 1 = data) take effect only while cfg_mode_i is high. With cfg_mode_i low, a write changes no register and no output.
- R3: While cfg_mode_i is high, rdata_o returns the index for addr_sel_i = 0 and the full stored byte of the indexed routing register for addr_sel_i = 1. While cfg_mode_i is low, rdata_o is 00h. Reads are combinational.
- R4: A data write while the index holds a value other than 26h (DMA select), 27h (parallel-port IRQ select) or 28h (UART IRQ selects) changes nothing, and a data read under such an index returns 00h.
- R5: DMA select bits 3:0 route the parallel-port request as follows: code 1 to drq 0, code 2 to drq 1, code 3 to drq 2. Any other code, and the upper nibble, enables no DRQ pin. A selected pin carries pp_drq_i. All other DRQ enables are low.
- R6: IRQ code decode: codes 1 to 6 select irq pins 0 to 5, and code 8 selects pin 6. Codes 0, 7 and 9 to 15 select nothing. A pin selected by the parallel port is enabled and carries pp_irq_i.
- R7: In register 28h, bits 7:4 are the UART1 select and bits 3:0 are the UART2 select. Both use the R6 decode.
- R8: A UART that owns a pin enables it only while its OUT2 input is 1. When enabled, the pin equals that UART's interrupt.
- R9: A UART2 field of 1111b selects shared mode. UART2 then drives no pin of its own. UART1's pin is enabled when either OUT2 is 1 and is high when any UART with OUT2 = 1 has its interrupt asserted.
- R10: When several sources select one pin, the parallel port owns it over UART1, and UART1 over UART2. The lower source then has no effect on that pin.
- R11: A pin whose enable is low outputs 0, and a pin that no source selects has its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | Configuration state active |
| wr_en_i | input | 1 | Write strobe for the addressed port |
| addr_sel_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| pp_irq_i | input | 1 | Parallel-port interrupt request |
| pp_drq_i | input | 1 | Parallel-port DMA request |
| uart1_irq_i | input | 1 | UART1 interrupt request |
| uart1_out2_i | input | 1 | UART1 OUT2 drive gate |
| uart2_irq_i | input | 1 | UART2 interrupt request |
| uart2_out2_i | input | 1 | UART2 OUT2 drive gate |
| irq_o | output | 7 | IRQ pin values |
| irq_oe_o | output | 7 | IRQ pin output enables |
| drq_o | output | 3 | DRQ pin values |
| drq_oe_o | output | 3 | DRQ pin output enables |

## Verification
The assertions assume that the host strobes cfg_mode_i, wr_en_i, addr_sel_i and wdata_i synchronously and holds them at known values after reset. They also assume that the peripheral request and OUT2 lines never carry X. The bench drives all control lines on the falling edge, so every write is captured cleanly at the next rising edge. It changes peripheral lines only between rising edges and samples the combinational outputs a step later. The sweep covers all three select codes and all 32 peripheral input combinations, which exercises every priority and sharing case.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SEL_W    = 4;
  localparam logic [DATA_W-1:0] IDX_DMA  = 8'h26;
  localparam logic [DATA_W-1:0] IDX_PPIRQ = 8'h27;
  localparam logic [DATA_W-1:0] IDX_UART = 8'h28;
  localparam logic [SEL_W-1:0]  SHARE_CODE = 4'hF;

  // code that selects IRQ pin p: pins below 6 are sparse-free, pin 6 skips reserved code 7
  function automatic logic [SEL_W-1:0] irq_code_of_pin(int unsigned p);
    return (p < 6) ? SEL_W'(p + 1) : SEL_W'(p + 2);
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              wr_en_i,
  input  logic              addr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] dma_sel_o,
  output logic [DATA_W-1:0] ppirq_sel_o,
  output logic [DATA_W-1:0] uart_sel_o
);
  logic [DATA_W-1:0] index_q, dma_q, ppirq_q, uart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      dma_q   <= '0;
      ppirq_q <= '0;
      uart_q  <= '0;
    end else if (cfg_mode_i && wr_en_i) begin
      if (!addr_sel_i) begin
        index_q <= wdata_i;
      end else begin
        unique case (index_q)
          IDX_DMA:   dma_q   <= wdata_i;
          IDX_PPIRQ: ppirq_q <= wdata_i;
          IDX_UART:  uart_q  <= wdata_i;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cfg_mode_i) begin
      if (!addr_sel_i) begin
        rdata_o = index_q;
      end else begin
        unique case (index_q)
          IDX_DMA:   rdata_o = dma_q;
          IDX_PPIRQ: rdata_o = ppirq_q;
          IDX_UART:  rdata_o = uart_q;
          default:   rdata_o = '0;
        endcase
      end
    end
  end

  assign dma_sel_o   = dma_q;
  assign ppirq_sel_o = ppirq_q;
  assign uart_sel_o  = uart_q;
endmodule

// File: rtl/irq_code_dec.sv
module irq_code_dec
  import irq_route_pkg::*;
#(
  parameter int unsigned N_PINS = 7
) (
  input  logic [SEL_W-1:0]  code_i,
  input  logic              en_i,
  output logic [N_PINS-1:0] hit_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign hit_o[p] = en_i && (code_i == irq_code_of_pin(p));
  end
endmodule

// File: rtl/irq_pin_arbiter.sv
module irq_pin_arbiter #(
  parameter int unsigned N_PINS = 7
) (
  input  logic [N_PINS-1:0] pp_hit_i,
  input  logic [N_PINS-1:0] u1_hit_i,
  input  logic [N_PINS-1:0] u2_hit_i,
  input  logic              shared_i,
  input  logic              pp_irq_i,
  input  logic              u1_irq_i,
  input  logic              u1_out2_i,
  input  logic              u2_irq_i,
  input  logic              u2_out2_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o
);
  logic u1_oe, u1_val, u2_oe, u2_val;

  // shared mode folds UART2 into UART1's slot
  assign u2_oe  = u2_out2_i;
  assign u2_val = u2_out2_i & u2_irq_i;
  assign u1_oe  = u1_out2_i | (shared_i & u2_oe);
  assign u1_val = (u1_out2_i & u1_irq_i) | (shared_i & u2_val);

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    always_comb begin
      if (pp_hit_i[p]) begin
        pin_oe_o[p] = 1'b1;
        pin_o[p]    = pp_irq_i;
      end else if (u1_hit_i[p]) begin
        pin_oe_o[p] = u1_oe;
        pin_o[p]    = u1_val;
      end else if (u2_hit_i[p]) begin
        pin_oe_o[p] = u2_oe;
        pin_o[p]    = u2_val;
      end else begin
        pin_oe_o[p] = 1'b0;
        pin_o[p]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/drq_router.sv
module drq_router
  import irq_route_pkg::*;
#(
  parameter int unsigned N_DRQ = 3
) (
  input  logic [SEL_W-1:0] code_i,
  input  logic             drq_i,
  output logic [N_DRQ-1:0] drq_o,
  output logic [N_DRQ-1:0] drq_oe_o
);
  for (genvar k = 0; k < N_DRQ; k++) begin : g_ch
    assign drq_oe_o[k] = (code_i == SEL_W'(k + 1));
    assign drq_o[k]    = drq_oe_o[k] & drq_i;
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IRQ = 7,
  parameter int unsigned N_DRQ = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              wr_en_i,
  input  logic              addr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pp_irq_i,
  input  logic              pp_drq_i,
  input  logic              uart1_irq_i,
  input  logic              uart1_out2_i,
  input  logic              uart2_irq_i,
  input  logic              uart2_out2_i,
  output logic [N_IRQ-1:0]  irq_o,
  output logic [N_IRQ-1:0]  irq_oe_o,
  output logic [N_DRQ-1:0]  drq_o,
  output logic [N_DRQ-1:0]  drq_oe_o
);
  logic [DATA_W-1:0] dma_sel_q, ppirq_sel_q, uart_sel_q;
  logic [SEL_W-1:0]  u1_code, u2_code;
  logic              shared;
  logic [N_IRQ-1:0]  pp_hit, u1_hit, u2_hit;

  irq_route_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (cfg_mode_i),
    .wr_en_i    (wr_en_i),
    .addr_sel_i (addr_sel_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .dma_sel_o  (dma_sel_q),
    .ppirq_sel_o(ppirq_sel_q),
    .uart_sel_o (uart_sel_q)
  );

  assign u1_code = uart_sel_q[2*SEL_W-1:SEL_W];
  assign u2_code = uart_sel_q[SEL_W-1:0];
  assign shared  = (u2_code == SHARE_CODE);

  irq_code_dec #(.N_PINS(N_IRQ)) u_dec_pp (
    .code_i(ppirq_sel_q[SEL_W-1:0]), .en_i(1'b1), .hit_o(pp_hit));
  irq_code_dec #(.N_PINS(N_IRQ)) u_dec_u1 (
    .code_i(u1_code), .en_i(1'b1), .hit_o(u1_hit));
  irq_code_dec #(.N_PINS(N_IRQ)) u_dec_u2 (
    .code_i(u2_code), .en_i(!shared), .hit_o(u2_hit));

  irq_pin_arbiter #(.N_PINS(N_IRQ)) u_arb (
    .pp_hit_i (pp_hit),
    .u1_hit_i (u1_hit),
    .u2_hit_i (u2_hit),
    .shared_i (shared),
    .pp_irq_i (pp_irq_i),
    .u1_irq_i (uart1_irq_i),
    .u1_out2_i(uart1_out2_i),
    .u2_irq_i (uart2_irq_i),
    .u2_out2_i(uart2_out2_i),
    .pin_o    (irq_o),
    .pin_oe_o (irq_oe_o)
  );

  drq_router #(.N_DRQ(N_DRQ)) u_drq (
    .code_i  (dma_sel_q[SEL_W-1:0]),
    .drq_i   (pp_drq_i),
    .drq_o   (drq_o),
    .drq_oe_o(drq_oe_o)
  );
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IRQ = 7,
  parameter int unsigned N_DRQ = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_mode_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              uart1_out2_i,
  input logic              uart2_out2_i,
  input logic [N_IRQ-1:0]  irq_o,
  input logic [N_IRQ-1:0]  irq_oe_o,
  input logic [N_DRQ-1:0]  drq_oe_o,
  input logic [DATA_W-1:0] dma_sel_q,
  input logic [DATA_W-1:0] ppirq_sel_q,
  input logic [DATA_W-1:0] uart_sel_q
);
  function automatic logic code_valid(logic [SEL_W-1:0] c);
    return ((c >= 4'd1) && (c <= 4'd6)) || (c == 4'd8);
  endfunction

  logic pp_none, u1_none, u2_none;
  assign pp_none = !code_valid(ppirq_sel_q[3:0]);
  assign u1_none = !code_valid(uart_sel_q[7:4]);
  assign u2_none = !code_valid(uart_sel_q[3:0]);

  AST_HOLD_OUTSIDE_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |=> $stable({dma_sel_q, ppirq_sel_q, uart_sel_q})); // R2
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |-> (rdata_o == '0)); // R3
  AST_DRQ_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drq_oe_o)); // R5
  AST_DRQ_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_oe_o != '0) |-> (dma_sel_q[3:0] inside {4'd1, 4'd2, 4'd3})); // R5
  AST_OUT2_GATES_UARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pp_none && !uart1_out2_i && !uart2_out2_i) |-> (irq_oe_o == '0)); // R8
  AST_UNSELECTED_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pp_none && u1_none && u2_none) |-> (irq_oe_o == '0)); // R11
  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~irq_oe_o) == '0)); // R11
endmodule

bind irq_dma_router irq_dma_router_chk #(.N_IRQ(N_IRQ), .N_DRQ(N_DRQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_mode_i  (cfg_mode_i),
  .rdata_o     (rdata_o),
  .uart1_out2_i(uart1_out2_i),
  .uart2_out2_i(uart2_out2_i),
  .irq_o       (irq_o),
  .irq_oe_o    (irq_oe_o),
  .drq_oe_o    (drq_oe_o),
  .dma_sel_q   (dma_sel_q),
  .ppirq_sel_q (ppirq_sel_q),
  .uart_sel_q  (uart_sel_q)
);

// File: tb/irq_dma_router_tb_top.sv
module irq_dma_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_mode_i = 1'b0, wr_en_i = 1'b0, addr_sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pp_irq_i = 0, pp_drq_i = 0, uart1_irq_i = 0, uart1_out2_i = 0;
  logic       uart2_irq_i = 0, uart2_out2_i = 0;
  logic [6:0] irq_o, irq_oe_o;
  logic [2:0] drq_o, drq_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_dma_router dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_mode_i(cfg_mode_i), .wr_en_i(wr_en_i),
    .addr_sel_i(addr_sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pp_irq_i(pp_irq_i), .pp_drq_i(pp_drq_i), .uart1_irq_i(uart1_irq_i),
    .uart1_out2_i(uart1_out2_i), .uart2_irq_i(uart2_irq_i), .uart2_out2_i(uart2_out2_i),
    .irq_o(irq_o), .irq_oe_o(irq_oe_o), .drq_o(drq_o), .drq_oe_o(drq_oe_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    addr_sel_i = sel; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    bus_write(1'b0, idx);
    bus_write(1'b1, d);
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
    bus_write(1'b0, idx);
    addr_sel_i = 1'b1;
    #1 d = rdata_o;
  endtask

  function automatic int pin_of(int c);
    if (c >= 1 && c <= 6) return c - 1;
    if (c == 8) return 6;
    return -1;
  endfunction

  // expected IRQ outputs, returned as {oe, val}
  function automatic logic [13:0] model_irq(int ppc, int u1c, int u2c, logic [4:0] in);
    logic [6:0] oe, v;
    logic pi, i1, o1, i2, o2, sh;
    int pp, u1, u2;
    {pi, i1, o1, i2, o2} = in;
    sh = (u2c == 15);
    pp = pin_of(ppc); u1 = pin_of(u1c); u2 = sh ? -1 : pin_of(u2c);
    oe = '0; v = '0;
    for (int p = 0; p < 7; p++) begin
      if (pp == p) begin
        oe[p] = 1'b1; v[p] = pi;
      end else if (u1 == p) begin
        oe[p] = sh ? (o1 | o2) : o1;
        v[p]  = (o1 & i1) | (sh & o2 & i2);
      end else if (u2 == p) begin
        oe[p] = o2; v[p] = o2 & i2;
      end
    end
    return {oe, v};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [13:0] exp;
    string tag;
    // R1: during and after reset
    cfg_mode_i = 1'b1;
    #1;
    check("R1 irq_oe in reset", irq_oe_o, 0);
    check("R1 drq_oe in reset", drq_oe_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    addr_sel_i = 1'b0; #1;
    check("R1 index reset", rdata_o, 8'h00);
    read_reg(8'h26, rd); check("R1 dma reset", rd, 8'h00);
    read_reg(8'h27, rd); check("R1 ppirq reset", rd, 8'h00);
    read_reg(8'h28, rd); check("R1 uart reset", rd, 8'h00);

    // R3: index readback
    bus_write(1'b0, 8'h5A); addr_sel_i = 1'b0; #1;
    check("R3 index readback", rdata_o, 8'h5A);

    // R2: writes ignored outside config state
    set_reg(8'h27, 8'h01);
    set_reg(8'h28, 8'h23);
    cfg_mode_i = 1'b0;
    bus_write(1'b0, 8'h26);
    bus_write(1'b1, 8'hF3);
    addr_sel_i = 1'b1; #1;
    check("R3 read outside cfg", rdata_o, 8'h00);
    addr_sel_i = 1'b0; #1;
    check("R3 index read outside cfg", rdata_o, 8'h00);
    check("R2 no drq after ignored write", drq_oe_o, 0);
    cfg_mode_i = 1'b1;
    addr_sel_i = 1'b0; #1;
    check("R2 index kept", rdata_o, 8'h28);
    read_reg(8'h26, rd); check("R2 dma kept", rd, 8'h00);
    read_reg(8'h27, rd); check("R2 ppirq kept", rd, 8'h01);

    // R4: unknown index
    set_reg(8'h25, 8'hFF);
    addr_sel_i = 1'b1; #1;
    check("R4 unknown index reads zero", rdata_o, 8'h00);
    set_reg(8'h29, 8'hFF);
    read_reg(8'h26, rd); check("R4 dma untouched", rd, 8'h00);
    read_reg(8'h27, rd); check("R4 ppirq untouched", rd, 8'h01);
    read_reg(8'h28, rd); check("R4 uart untouched", rd, 8'h23);

    // R5: DMA select sweep
    for (int c = 0; c < 16; c++) begin
      set_reg(8'h26, {~c[3:0], c[3:0]});
      addr_sel_i = 1'b1; #1;
      check("R5 R3 dma readback", rdata_o, {~c[3:0], c[3:0]});
      for (int d = 0; d < 2; d++) begin
        logic [2:0] eoe;
        eoe = (c >= 1 && c <= 3) ? 3'(1 << (c - 1)) : 3'b000;
        pp_drq_i = d[0]; #1;
        check("R5 drq_oe", drq_oe_o, eoe);
        check("R5 drq value", drq_o, d[0] ? eoe : 3'b000);
      end
    end
    pp_drq_i = 1'b0;

    // R6..R11: full sweep of IRQ selects and peripheral inputs
    for (int ppc = 0; ppc < 16; ppc++) begin
      set_reg(8'h27, 8'(ppc));
      for (int u1c = 0; u1c < 16; u1c++) begin
        for (int u2c = 0; u2c < 16; u2c++) begin
          set_reg(8'h28, {u1c[3:0], u2c[3:0]});
          addr_sel_i = 1'b1; #1;
          check("R7 uart field readback", rdata_o, {u1c[3:0], u2c[3:0]});
          if (u2c == 15) tag = "R9 shared irq";
          else if ((pin_of(ppc) >= 0 && (pin_of(ppc) == pin_of(u1c) || pin_of(ppc) == pin_of(u2c)))
                   || (pin_of(u1c) >= 0 && pin_of(u1c) == pin_of(u2c))) tag = "R10 priority";
          else if (ppc == 0) tag = "R7 R8 uart routing";
          else tag = "R6 R11 irq routing";
          for (int pat = 0; pat < 32; pat++) begin
            {pp_irq_i, uart1_irq_i, uart1_out2_i, uart2_irq_i, uart2_out2_i} = 5'(pat);
            #1;
            exp = model_irq(ppc, u1c, u2c, 5'(pat));
            check(tag, {irq_oe_o, irq_o}, exp);
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule